// File: doc/BRIEF.md
# Processor Interrupt Interface Unit

This unit sits between an interrupt distributor and one processor core. Each cycle the distributor offers its best pending interrupt as an ID, a priority and a group bit. The unit decides whether that interrupt may reach the core, given the priority mask, the priorities already being serviced and the preemption granularity set by the binary point. If it may, the unit raises the core's normal request line or its fast request line. Software on the core claims the interrupt by reading the acknowledge register and releases it by writing the same ID to the end-of-interrupt register. The distributor sees both events as one-cycle pulses that carry the ID.

The priorities being serviced are kept on a small stack, so handlers can nest. The top entry is the running priority. A new interrupt preempts only if its group priority is strictly more urgent than the group priority of the running one. Priorities are unsigned, and a lower value is more urgent.

A state machine tracks stack occupancy in three states. `OCC_IDLE` means nothing is active, `OCC_NESTED` means one or more entries are active with room left, and `OCC_FULL` means all `DEPTH` entries are in use. It has five transitions:
- ack-first: `OCC_IDLE` to `OCC_NESTED`, or to `OCC_FULL` when `DEPTH` is 1.
- ack-nest: `OCC_NESTED` to `OCC_NESTED`, or to `OCC_FULL` when the last slot is taken.
- eoi-pop: `OCC_NESTED` to `OCC_NESTED`.
- eoi-last: `OCC_NESTED` to `OCC_IDLE`.
- eoi-full: `OCC_FULL` to `OCC_NESTED`, or to `OCC_IDLE` when `DEPTH` is 1.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the following hold:
  - `irq_o` and `fiq_o` are low.
  - The control, mask and binary-point registers read 0, so a mask of 0 blocks everything.
  - The running-priority register reads 0xFF.
- R2: Signalling requires all of the following, and a qualifying interrupt raises its request line one cycle after the inputs settle:
  - control bit 0 (enable) is 1;
  - `hp_valid` is high;
  - the priority passes the mask (R3);
  - the interrupt may preempt (R7);
  - the stack has room (R10).

  With enable at 0 both lines stay low.
- R3: An interrupt whose priority is greater than or equal to the mask (offset 0x04, bits 7:0) is neither signalled nor acknowledged.
- R4: Reading offset 0x0C when an interrupt qualifies has these effects:
  - The read returns `hp_id` in bits 9:0 on `reg_rdata`, in the cycle after the read strobe.
  - A one-cycle `ack_pulse` carries that ID on `ack_id`.
  - The priority is pushed, so running priority (offset 0x14) becomes that priority.
  - The request line drops on the same edge.
- R5: If nothing qualifies, or enable is 0, reading offset 0x0C returns the spurious ID 1023, produces no `ack_pulse`, and leaves the running priority unchanged.
- R6: Writing an ID to offset 0x10 behaves as follows:
  - If the ID equals the most recently acknowledged active ID, the top entry is popped and `eoi_pulse` fires with that ID on `eoi_id`. Running priority returns to the entry below, or to 0xFF when the stack is empty.
  - A non-matching ID is ignored: there is no pulse and the running priority is unchanged.
- R7: The group priority of a value p is p AND (0xFF shifted left by the binary point), where the binary point is offset 0x08, bits 2:0. A pending interrupt preempts only if its group priority is strictly lower than the running group priority. An empty stack has no running group, so any interrupt may preempt.
- R8: With control bit 1 set, a group-0 interrupt (`hp_group`=0) is signalled on `fiq_o`. Otherwise every interrupt is signalled on `irq_o`. The two lines are never high together.
- R9: Offset 0x18 returns `hp_prio` when `hp_valid` is high and 0xFF otherwise, regardless of the mask.
- R10: Once `DEPTH` (default 4) interrupts are active, no further interrupt is signalled, and an acknowledge returns 1023.
- R11: Control (offset 0x00, bits 1:0), mask and binary point read back the values written.
- R12: `virq_o` and `vfiq_o` are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_valid | input | 1 | Distributor offers a pending interrupt |
| hp_id | input | ID_W | ID of the offered interrupt |
| hp_prio | input | PRIO_W | Priority of the offered interrupt (lower is more urgent) |
| hp_group | input | 1 | Group of the offered interrupt (0 or 1) |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset within the unit |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| ack_pulse | output | 1 | An interrupt was acknowledged |
| ack_id | output | ID_W | ID acknowledged |
| eoi_pulse | output | 1 | An interrupt completed |
| eoi_id | output | ID_W | ID completed |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |
| virq_o | output | 1 | Virtual normal request, tied low |
| vfiq_o | output | 1 | Virtual fast request, tied low |

## Verification
The bench drives offered priorities on both sides of the mask to separate the strict less-than test from less-or-equal. It uses a pending priority that is more urgent than the running one in raw value but equal in group, and checks it under two binary-point settings, which shows that the preemption test uses the masked group rather than the raw priority. An end-of-interrupt with a stale ID, placed before the matching one, shows whether the ID comparison really guards the pop. Filling the stack to its depth and then offering a more urgent interrupt exercises the full-stack path, and unwinding it checks that each entry comes back in the right order.

// File: rtl/irq_cpu_port_pkg.sv
package irq_cpu_port_pkg;

    // Byte offsets of the register slots within the unit
    localparam int unsigned OFS_CTL   = 'h00;
    localparam int unsigned OFS_PMASK = 'h04;
    localparam int unsigned OFS_BPR   = 'h08;
    localparam int unsigned OFS_ACK   = 'h0C;
    localparam int unsigned OFS_EOI   = 'h10;
    localparam int unsigned OFS_RUN   = 'h14;
    localparam int unsigned OFS_HPP   = 'h18;

    // Occupancy of the active-priority stack
    typedef enum logic [1:0] {
        OCC_IDLE   = 2'd0,
        OCC_NESTED = 2'd1,
        OCC_FULL   = 2'd2
    } occ_e;

endpackage

// File: rtl/irq_cpu_port_stack.sv
module irq_cpu_port_stack #(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 10,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [ID_W-1:0]   push_id,
    output logic [PRIO_W-1:0] top_prio,
    output logic [ID_W-1:0]   top_id,
    output logic [CNT_W-1:0]  count
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [ID_W-1:0]   id_mem   [DEPTH];
    logic [IDX_W-1:0]  top_idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_mem[i] <= '0;
                id_mem[i]   <= '0;
            end else if (push && count == CNT_W'(i)) begin
                prio_mem[i] <= push_prio;
                id_mem[i]   <= push_id;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (push) count <= count + 1'b1;
        else if (pop)  count <= count - 1'b1;
    end

    assign top_idx  = IDX_W'(count - 1'b1);
    assign top_prio = (count == '0) ? '1 : prio_mem[top_idx];
    assign top_id   = (count == '0) ? '0 : id_mem[top_idx];

    // R10: a push never lands on a full stack
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));
    // R6: a pop never happens on an empty stack
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/irq_cpu_port_gate.sv
module irq_cpu_port_gate #(
    parameter int PRIO_W = 8,
    localparam int BPR_W = $clog2(PRIO_W)
) (
    input  logic              hp_valid,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic              hp_group,
    input  logic [PRIO_W-1:0] pmask,
    input  logic [BPR_W-1:0]  bpr,
    input  logic              run_empty,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stack_full,
    input  logic              fiq_route_en,
    output logic              eligible,
    output logic              to_fiq
);
    logic [PRIO_W-1:0] grp_mask;
    logic [PRIO_W:0]   hp_grp;
    logic [PRIO_W:0]   run_grp;

    always_comb begin
        grp_mask = {PRIO_W{1'b1}} << bpr;
        hp_grp   = {1'b0, hp_prio & grp_mask};
        // an empty stack sits one above the least urgent group
        run_grp  = run_empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, run_prio & grp_mask};
        eligible = hp_valid && (hp_prio < pmask) && (hp_grp < run_grp) && !stack_full;
        to_fiq   = fiq_route_en && !hp_group;
    end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
    import irq_cpu_port_pkg::*;
#(
    parameter int PRIO_W = 8,
    parameter int ID_W   = 10,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hp_valid,
    input  logic [ID_W-1:0]   hp_id,
    input  logic [PRIO_W-1:0] hp_prio,
    input  logic              hp_group,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ack_pulse,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_pulse,
    output logic [ID_W-1:0]   eoi_id,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              virq_o,
    output logic              vfiq_o
);
    localparam int BPR_W = $clog2(PRIO_W);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [ID_W-1:0] SPURIOUS = {ID_W{1'b1}};

    // configuration registers
    logic [1:0]        ctl_q;       // [0] signalling enable, [1] group-0 to fast line
    logic [PRIO_W-1:0] pmask_q;
    logic [BPR_W-1:0]  bpr_q;

    occ_e              occ_q, occ_d;
    logic [PRIO_W-1:0] run_prio;
    logic [ID_W-1:0]   run_id;
    logic [CNT_W-1:0]  stack_cnt;
    logic              eligible, to_fiq;
    logic              is_ack, is_eoi, ack_take, eoi_take;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:ID_W];

    assign is_ack   = reg_rd && !reg_wr && (reg_addr == ADDR_W'(OFS_ACK));
    assign is_eoi   = reg_wr && (reg_addr == ADDR_W'(OFS_EOI));
    assign ack_take = is_ack && ctl_q[0] && eligible;
    assign eoi_take = is_eoi && (occ_q != OCC_IDLE) && (reg_wdata[ID_W-1:0] == run_id);

    irq_cpu_port_stack #(.PRIO_W(PRIO_W), .ID_W(ID_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack_take),
        .pop       (eoi_take),
        .push_prio (hp_prio),
        .push_id   (hp_id),
        .top_prio  (run_prio),
        .top_id    (run_id),
        .count     (stack_cnt)
    );

    irq_cpu_port_gate #(.PRIO_W(PRIO_W)) u_gate (
        .hp_valid     (hp_valid),
        .hp_prio      (hp_prio),
        .hp_group     (hp_group),
        .pmask        (pmask_q),
        .bpr          (bpr_q),
        .run_empty    (occ_q == OCC_IDLE),
        .run_prio     (run_prio),
        .stack_full   (occ_q == OCC_FULL),
        .fiq_route_en (ctl_q[1]),
        .eligible     (eligible),
        .to_fiq       (to_fiq)
    );

    // configuration writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            pmask_q <= '0;
            bpr_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(OFS_CTL))   ctl_q   <= reg_wdata[1:0];
            if (reg_addr == ADDR_W'(OFS_PMASK)) pmask_q <= reg_wdata[PRIO_W-1:0];
            if (reg_addr == ADDR_W'(OFS_BPR))   bpr_q   <= reg_wdata[BPR_W-1:0];
        end
    end

    // occupancy transitions
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_IDLE: begin
                if (ack_take) occ_d = (DEPTH == 1) ? OCC_FULL : OCC_NESTED;        // ack-first
            end
            OCC_NESTED: begin
                if (ack_take && stack_cnt == CNT_W'(DEPTH - 1)) occ_d = OCC_FULL;  // ack-nest
                else if (eoi_take && stack_cnt == CNT_W'(1))    occ_d = OCC_IDLE;  // eoi-last
            end
            OCC_FULL: begin
                if (eoi_take) occ_d = (DEPTH == 1) ? OCC_IDLE : OCC_NESTED;        // eoi-full
            end
            default: occ_d = OCC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= OCC_IDLE;
        else        occ_q <= occ_d;
    end

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(OFS_CTL))   rd_mux = DATA_W'(ctl_q);
        if (reg_addr == ADDR_W'(OFS_PMASK)) rd_mux = DATA_W'(pmask_q);
        if (reg_addr == ADDR_W'(OFS_BPR))   rd_mux = DATA_W'(bpr_q);
        if (reg_addr == ADDR_W'(OFS_ACK))   rd_mux = DATA_W'(ack_take ? hp_id : SPURIOUS);
        if (reg_addr == ADDR_W'(OFS_RUN))   rd_mux = DATA_W'(run_prio);
        if (reg_addr == ADDR_W'(OFS_HPP))   rd_mux = DATA_W'(hp_valid ? hp_prio : {PRIO_W{1'b1}});
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            fiq_o     <= 1'b0;
            ack_pulse <= 1'b0;
            ack_id    <= '0;
            eoi_pulse <= 1'b0;
            eoi_id    <= '0;
            reg_rdata <= '0;
        end else begin
            irq_o     <= ctl_q[0] && eligible && !ack_take && !to_fiq;
            fiq_o     <= ctl_q[0] && eligible && !ack_take && to_fiq;
            ack_pulse <= ack_take;
            eoi_pulse <= eoi_take;
            if (ack_take) ack_id <= hp_id;
            if (eoi_take) eoi_id <= reg_wdata[ID_W-1:0];
            if (reg_rd && !reg_wr) reg_rdata <= rd_mux;
        end
    end

    assign virq_o = 1'b0;
    assign vfiq_o = 1'b0;

    // R2: no request one cycle after enable was low
    a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_q[0]) |-> (!irq_o && !fiq_o));
    // R3: a raised line came from a valid, unmasked offer
    a_r3_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> ($past(hp_valid) && $past(hp_prio < pmask_q)));
    // R8: only one core line at a time
    a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o));
    // R4: accepted acknowledge sets running priority to the acknowledged one
    a_r4_ack_raises_running: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (run_prio == $past(hp_prio)));
    // R5: a spurious acknowledge leaves the stack alone
    a_r5_spurious_still: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ack && !ack_take) |=> ($stable(stack_cnt) && !ack_pulse));
    // R6: an accepted end-of-interrupt removes exactly one entry
    a_r6_eoi_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_take |=> (stack_cnt == $past(stack_cnt) - 1'b1));
endmodule

// File: tb/sim_irq_cpu_port.sv
module sim_irq_cpu_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hp_valid;
    logic [9:0]  hp_id;
    logic [7:0]  hp_prio;
    logic        hp_group;
    logic        reg_rd, reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        ack_pulse, eoi_pulse;
    logic [9:0]  ack_id, eoi_id;
    logic        irq_o, fiq_o, virq_o, vfiq_o;

    int   n_chk = 0;
    int   n_bad = 0;
    logic last_ack, last_eoi;
    logic [9:0] last_ack_id, last_eoi_id;

    localparam logic [4:0] A_CTL = 5'h00, A_PMASK = 5'h04, A_BPR = 5'h08, A_ACK = 5'h0C,
                           A_EOI = 5'h10, A_RUN = 5'h14, A_HPP = 5'h18;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cpu_port u0 (
        .clk(clk), .rst_n(rst_n), .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio),
        .hp_group(hp_group), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_pulse(ack_pulse), .ack_id(ack_id),
        .eoi_pulse(eoi_pulse), .eoi_id(eoi_id), .irq_o(irq_o), .fiq_o(fiq_o),
        .virq_o(virq_o), .vfiq_o(vfiq_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; last_eoi = eoi_pulse; last_eoi_id = eoi_id;
    endtask

    task automatic do_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0; d = reg_rdata; last_ack = ack_pulse; last_ack_id = ack_id;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p, input logic g);
        hp_valid = v; hp_id = id; hp_prio = p; hp_group = g;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "irq after reset", 32'(irq_o), 0);
        chk("R1", "fiq after reset", 32'(fiq_o), 0);
        chk("R12", "virtual lines", 32'({virq_o, vfiq_o}), 0);
        do_read(A_CTL, d);   chk("R1", "control", d, 0);
        do_read(A_PMASK, d); chk("R1", "mask", d, 0);
        do_read(A_RUN, d);   chk("R1", "running idle", d, 32'hFF);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        do_write(A_CTL, 32'h3);    do_read(A_CTL, d);   chk("R11", "control readback", d, 3);
        do_write(A_CTL, 32'h1);
        do_write(A_PMASK, 32'hF0); do_read(A_PMASK, d); chk("R11", "mask readback", d, 32'hF0);
        do_write(A_BPR, 32'h5);    do_read(A_BPR, d);   chk("R11", "bpr readback", d, 5);
        do_write(A_BPR, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        offer(1'b1, 10'd33, 8'hF0, 1'b1); settle();
        chk("R3", "irq at prio == mask", 32'(irq_o), 0);
        do_read(A_ACK, d); chk("R3", "ack at prio == mask", d, 1023);
        offer(1'b1, 10'd33, 8'hEF, 1'b1); settle();
        chk("R2", "irq at prio just under mask", 32'(irq_o), 1);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        do_write(A_CTL, 32'h0); settle();
        chk("R2", "irq with enable low", 32'(irq_o), 0);
        do_read(A_ACK, d); chk("R5", "ack with enable low", d, 1023);
        chk("R5", "no ack pulse when disabled", 32'(last_ack), 0);
        do_read(A_RUN, d); chk("R5", "running unchanged", d, 32'hFF);
        do_write(A_CTL, 32'h1);
        offer(1'b0, 10'd0, 8'hFF, 1'b1); settle();
    endtask

    task automatic t_ack();
        logic [31:0] d;
        offer(1'b1, 10'd57, 8'h84, 1'b1); settle();
        chk("R2", "irq raised", 32'(irq_o), 1);
        do_read(A_ACK, d);
        chk("R4", "ack returns id", d, 57);
        chk("R4", "ack pulse", 32'(last_ack), 1);
        chk("R4", "ack id to distributor", 32'(last_ack_id), 57);
        chk("R4", "irq drops after ack", 32'(irq_o), 0);
        offer(1'b0, 10'd0, 8'hFF, 1'b1);
        do_read(A_RUN, d); chk("R4", "running after ack", d, 32'h84);
    endtask

    task automatic t_spurious();
        logic [31:0] d;
        do_read(A_ACK, d); chk("R5", "ack with nothing pending", d, 1023);
        chk("R5", "no pulse on spurious", 32'(last_ack), 0);
        do_read(A_RUN, d); chk("R5", "running kept", d, 32'h84);
        do_read(A_HPP, d); chk("R9", "highest pending when none", d, 32'hFF);
    endtask

    task automatic t_preempt();
        logic [31:0] d;
        do_write(A_BPR, 32'h3);
        offer(1'b1, 10'd90, 8'h82, 1'b1); settle(); settle();
        chk("R7", "same group does not preempt", 32'(irq_o), 0);
        do_read(A_HPP, d); chk("R9", "highest pending prio", d, 32'h82);
        do_write(A_BPR, 32'h1); settle();
        chk("R7", "finer group preempts", 32'(irq_o), 1);
        do_read(A_ACK, d); chk("R7", "nested ack", d, 90);
        offer(1'b0, 10'd0, 8'hFF, 1'b1);
        do_read(A_RUN, d); chk("R7", "running nested", d, 32'h82);
    endtask

    task automatic t_eoi();
        logic [31:0] d;
        do_write(A_EOI, 32'd57);
        chk("R6", "stale eoi no pulse", 32'(last_eoi), 0);
        do_read(A_RUN, d); chk("R6", "stale eoi ignored", d, 32'h82);
        do_write(A_EOI, 32'd90);
        chk("R6", "eoi pulse", 32'(last_eoi), 1);
        chk("R6", "eoi id", 32'(last_eoi_id), 90);
        do_read(A_RUN, d); chk("R6", "running restored", d, 32'h84);
        do_write(A_EOI, 32'd57);
        do_read(A_RUN, d); chk("R6", "running idle again", d, 32'hFF);
    endtask

    task automatic t_fiq();
        do_write(A_CTL, 32'h3);
        offer(1'b1, 10'd40, 8'h10, 1'b0); settle();
        chk("R8", "group0 fiq", 32'({irq_o, fiq_o}), 32'b01);
        offer(1'b1, 10'd41, 8'h10, 1'b1); settle();
        chk("R8", "group1 irq", 32'({irq_o, fiq_o}), 32'b10);
        do_write(A_CTL, 32'h1);
        offer(1'b1, 10'd40, 8'h10, 1'b0); settle();
        chk("R8", "group0 irq when routing off", 32'({irq_o, fiq_o}), 32'b10);
        offer(1'b0, 10'd0, 8'hFF, 1'b1); settle();
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            offer(1'b1, 10'(100 + i), 8'(8'h40 - 8'(16 * i)), 1'b1);
            do_read(A_ACK, d); chk("R10", "fill ack", d, 32'(100 + i));
        end
        offer(1'b1, 10'd104, 8'h08, 1'b1); settle();
        chk("R10", "no signal when full", 32'(irq_o), 0);
        do_read(A_ACK, d); chk("R10", "ack when full", d, 1023);
        offer(1'b0, 10'd0, 8'hFF, 1'b1);
        do_read(A_RUN, d); chk("R10", "running at depth", d, 32'h10);
        for (int i = 3; i >= 0; i--) begin
            do_write(A_EOI, 32'(100 + i));
            chk("R6", "unwind pulse", 32'(last_eoi), 1);
        end
        do_read(A_RUN, d); chk("R6", "unwound", d, 32'hFF);
        chk("R12", "virtual lines at end", 32'({virq_o, vfiq_o}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        offer(1'b0, 10'd0, 8'hFF, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_mask();
        t_disable();
        t_ack();
        t_spurious();
        t_preempt();
        t_eoi();
        t_fiq();
        t_full();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule